// File: doc/BRIEF.md
# Multicore Snoop-Control Register Block

This block is the software-visible register window of a multicore coherence controller. It occupies 256 bytes of address space and is reached through a simple synchronous register bus. The bus carries an 8-bit byte offset, separate read and write strobes, an access size given as a byte count, write data and registered read data.

Three kinds of state are visible through the window:
- A single enable bit that switches coherence on.
- A read-only configuration word built from the core-count parameter.
- A 32-bit power-state word with one byte per core. Software can read it through four adjacent byte offsets and update it with byte, halfword or word writes. A write changes only the lanes its size and offset select.

A few maintenance, address-filter and access-control offsets are decoded but have no effect: they read as zero and drop writes. Every other offset in the window does the same. The core count `CORE_COUNT` may be 1 to 4.

Top module: `snoopRegBlock`

## Requirements
- R1: Offset 0x00 holds the coherence-enable bit. A write stores bit 0 of the write data and discards the other bits. A read returns the stored bit in bit 0 and zeros in bits 31:1.
- R2: Offset 0x04 reads as a constant. Bits 3:0 hold `CORE_COUNT-1`, and the bits from bit 4 up hold `CORE_COUNT` ones (0x31 for two cores, 0xF3 for four). Writes to 0x04 change nothing.
- R3: A read at offset 0x08+k, for k = 0..3, returns the power-state word shifted right by 8·k bits, with zeros filled in from the top.
- R4: A write at 0x08+k uses a base mask of 0xFF, 0xFFFF or 0xFFFFFFFF when `regSize` is 1, 2 or 4.
  - The base mask is moved left by 8·k bits, and mask bits that pass bit 31 are dropped.
  - The write data is moved left by the same amount.
  - Bits under the mask take the moved data. Bits outside the mask keep their value.
- R5: A write whose `regSize` is not 1, 2 or 4 changes no register, at any offset.
- R6: Offsets 0x0C, 0x40, 0x44, 0x50 and 0x54, and every offset not named in R1 to R4, read as zero and ignore writes.
- R7: `regRdata` is registered. It shows the selected value in the cycle after `regRead` is sampled and holds that value while `regRead` is low. A read sampled in the same cycle as a write returns the value from before the write.
- R8: After reset, the enable bit, the power-state word and `regRdata` are all zero.
- R9: A write takes effect at the clock edge where `regWrite` is sampled, so a read in the next cycle returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 8 | Byte offset within the window |
| regRead | input | 1 | Read strobe |
| regWrite | input | 1 | Write strobe |
| regSize | input | 3 | Access size in bytes (1, 2 or 4 are valid) |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Registered read data |

## Verification
The bench focuses on lane arithmetic in the power-state word:
- A halfword write at 0x0A and word writes at 0x0B overflow past bit 31. A design that kept the overflowed mask bits, or wrapped them around, would corrupt the low bytes.
- A byte write at 0x09 checks that neighbouring bytes survive. A mask that was not inverted correctly would clear them.

Writes with sizes 0, 3, 5 and 7 are sent to the enable and power registers. A design that treated these as word writes would visibly change state.

Zero offsets are written and then read back, which catches decode that aliases onto real registers. A read issued together with a write checks the pre-write read value, and an idle interval checks that read data holds.

// File: rtl/snoop_reg_pkg.sv
package snoop_reg_pkg;

  typedef enum logic [1:0] {
    SEL_ZERO = 2'd0,
    SEL_CTL  = 2'd1,
    SEL_CFG  = 2'd2,
    SEL_PWR  = 2'd3
  } readSel_e;

  typedef struct packed {
    logic       ctlWr;
    logic       pwrWr;
    logic       rdEn;
    readSel_e   rdSel;
    logic [1:0] lane;
    logic [31:0] laneMask;
  } regStrobe_t;

endpackage

// File: rtl/snoop_reg_ctrl.sv
module snoopRegCtrl
  import snoop_reg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regRead,
  input  logic              regWrite,
  input  logic [2:0]        regSize,
  output regStrobe_t        strobe
);
  localparam logic [ADDR_W-1:0] OFS_CTL = 'h00;
  localparam logic [ADDR_W-1:0] OFS_CFG = 'h04;
  localparam logic [ADDR_W-3:0] PWR_WORD = (ADDR_W-2)'(2);

  logic              sizeOk;
  logic [DATA_W-1:0] sizeMask;
  logic              isPwr;

  always_comb begin
    sizeOk   = 1'b1;
    sizeMask = '0;
    case (regSize)
      3'd1:    sizeMask = DATA_W'(32'h0000_00FF);
      3'd2:    sizeMask = DATA_W'(32'h0000_FFFF);
      3'd4:    sizeMask = '1;
      default: sizeOk = 1'b0;
    endcase
  end

  assign isPwr = (regAddr[ADDR_W-1:2] == PWR_WORD);

  always_comb begin
    strobe          = '0;
    strobe.rdEn     = regRead;
    strobe.lane     = regAddr[1:0];
    strobe.ctlWr    = regWrite && sizeOk && (regAddr == OFS_CTL);
    strobe.pwrWr    = regWrite && sizeOk && isPwr;
    strobe.laneMask = sizeMask << {regAddr[1:0], 3'b000};
    if (regAddr == OFS_CTL)      strobe.rdSel = SEL_CTL;
    else if (regAddr == OFS_CFG) strobe.rdSel = SEL_CFG;
    else if (isPwr)              strobe.rdSel = SEL_PWR;
    else                         strobe.rdSel = SEL_ZERO;
  end
endmodule

// File: rtl/snoop_reg_data.sv
module snoopRegData
  import snoop_reg_pkg::*;
#(
  parameter int CORE_COUNT = 2,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata
);
  localparam int PRESENT_LSB = 4;
  localparam logic [DATA_W-1:0] CFG_WORD =
      (DATA_W'((1 << CORE_COUNT) - 1) << PRESENT_LSB) | DATA_W'(CORE_COUNT - 1);

  logic              ctlBit;
  logic [DATA_W-1:0] pwrWord;
  logic [DATA_W-1:0] laneData;
  logic [DATA_W-1:0] rdValue;

  assign laneData = regWdata << {strobe.lane, 3'b000};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlBit  <= 1'b0;
      pwrWord <= '0;
    end else begin
      if (strobe.ctlWr) ctlBit <= regWdata[0];
      if (strobe.pwrWr) pwrWord <= (pwrWord & ~strobe.laneMask) | (laneData & strobe.laneMask);
    end
  end

  always_comb begin
    case (strobe.rdSel)
      SEL_CTL: rdValue = {{(DATA_W-1){1'b0}}, ctlBit};
      SEL_CFG: rdValue = CFG_WORD;
      SEL_PWR: rdValue = pwrWord >> {strobe.lane, 3'b000};
      default: rdValue = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            regRdata <= '0;
    else if (strobe.rdEn) regRdata <= rdValue;
  end
endmodule

// File: rtl/snoop_reg_block.sv
module snoopRegBlock
  import snoop_reg_pkg::*;
#(
  parameter int CORE_COUNT = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  regAddr,
  input  logic        regRead,
  input  logic        regWrite,
  input  logic [2:0]  regSize,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata
);
  regStrobe_t strobe;

  if (CORE_COUNT < 1 || CORE_COUNT > 4) begin : g_badCount
    initial $error("snoopRegBlock: CORE_COUNT must be 1 to 4");
  end

  snoopRegCtrl #(.ADDR_W(8), .DATA_W(32)) ctrl_i (
    .regAddr (regAddr),
    .regRead (regRead),
    .regWrite(regWrite),
    .regSize (regSize),
    .strobe  (strobe)
  );

  snoopRegData #(.CORE_COUNT(CORE_COUNT), .DATA_W(32)) data_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .regWdata(regWdata),
    .regRdata(regRdata)
  );
endmodule

// File: rtl/snoop_reg_checker.sv
module snoopRegChecker #(
  parameter int CORE_COUNT = 2
) (
  input logic        clk,
  input logic        rstN,
  input logic [7:0]  regAddr,
  input logic        regRead,
  input logic [31:0] regRdata
);
  localparam logic [31:0] EXP_CFG = (32'((1 << CORE_COUNT) - 1) << 4) | 32'(CORE_COUNT - 1);

  logic zeroOfs;
  assign zeroOfs = (regAddr == 8'h0C) || (regAddr == 8'h40) || (regAddr == 8'h44) ||
                   (regAddr == 8'h50) || (regAddr == 8'h54) || (regAddr == 8'hFF);

  AST_CTL_ONE_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (regRead && regAddr == 8'h00) |=> (regRdata[31:1] == 31'd0)); // R1
  AST_CFG_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    (regRead && regAddr == 8'h04) |=> (regRdata == EXP_CFG)); // R2
  AST_LANE_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (regRead && regAddr == 8'h0B) |=> (regRdata[31:8] == 24'd0)); // R3
  AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rstN)
    (regRead && zeroOfs) |=> (regRdata == 32'd0)); // R6
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !regRead |=> $stable(regRdata)); // R7
endmodule

bind snoopRegBlock snoopRegChecker #(.CORE_COUNT(CORE_COUNT)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .regAddr (regAddr),
  .regRead (regRead),
  .regRdata(regRdata)
);

// File: tb/snoop_reg_block_tb.sv
module snoopRegBlock_tb_top;
  localparam int CORES = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regRead = 1'b0;
  logic        regWrite = 1'b0;
  logic [2:0]  regSize = 3'd4;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;

  int total = 0;
  int bad = 0;
  logic [31:0] expPwr = '0;
  logic        expCtl = 1'b0;

  always #2.5 clk = ~clk;

  snoopRegBlock #(.CORE_COUNT(CORES)) dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regRead(regRead),
    .regWrite(regWrite), .regSize(regSize), .regWdata(regWdata), .regRdata(regRdata)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pwrModel(logic [31:0] old, logic [1:0] lane,
                                           logic [2:0] sz, logic [31:0] d);
    logic [31:0] m;
    m = (sz == 3'd1) ? 32'hFF : (sz == 3'd2) ? 32'hFFFF : 32'hFFFF_FFFF;
    m = m << (8 * lane);
    return (old & ~m) | ((d << (8 * lane)) & m);
  endfunction

  task automatic doWrite(logic [7:0] a, logic [2:0] sz, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regSize = sz; regWdata = d; regWrite = 1'b1;
    @(negedge clk);
    regWrite = 1'b0;
    if (a[7:2] == 6'h02 && (sz == 3'd1 || sz == 3'd2 || sz == 3'd4))
      expPwr = pwrModel(expPwr, a[1:0], sz, d);
    if (a == 8'h00 && (sz == 3'd1 || sz == 3'd2 || sz == 3'd4))
      expCtl = d[0];
  endtask

  task automatic doRead(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; regRead = 1'b1;
    @(negedge clk);
    regRead = 1'b0;
    d = regRdata;
  endtask

  task automatic testReset();
    logic [31:0] d;
    check("R8 rdata after reset", regRdata, 32'd0);
    doRead(8'h00, d); check("R8 ctl after reset", d, 32'd0);
    doRead(8'h08, d); check("R8 pwr after reset", d, 32'd0);
  endtask

  task automatic testCtl();
    logic [31:0] d;
    doWrite(8'h00, 3'd4, 32'hFFFF_FFFE); doRead(8'h00, d); check("R1 even data", d, 32'd0);
    doWrite(8'h00, 3'd4, 32'h8000_0003); doRead(8'h00, d); check("R1 bit0 set", d, 32'd1);
    doWrite(8'h00, 3'd1, 32'h0000_0000); doRead(8'h00, d); check("R9 byte write ctl", d, 32'd0);
    doWrite(8'h00, 3'd4, 32'h1); doRead(8'h00, d); check("R1 set again", d, 32'd1);
  endtask

  task automatic testCfg();
    logic [31:0] d;
    doRead(8'h04, d); check("R2 cfg value", d, 32'h31);
    doWrite(8'h04, 3'd4, 32'h0);
    doRead(8'h04, d); check("R2 cfg after write", d, 32'h31);
  endtask

  task automatic testPwr();
    logic [31:0] d;
    doWrite(8'h08, 3'd4, 32'hA5C3_1234);
    doRead(8'h08, d); check("R4 word at 08", d, expPwr);
    doRead(8'h09, d); check("R3 lane 09", d, expPwr >> 8);
    doRead(8'h0A, d); check("R3 lane 0A", d, expPwr >> 16);
    doRead(8'h0B, d); check("R3 lane 0B", d, expPwr >> 24);
    doWrite(8'h09, 3'd1, 32'hFFFF_FF77);
    doRead(8'h08, d); check("R4 byte at 09", d, 32'hA5C3_7734);
    doWrite(8'h0A, 3'd2, 32'hDEAD_BEEF);
    doRead(8'h08, d); check("R4 half at 0A", d, 32'hBEEF_7734);
    doWrite(8'h0B, 3'd4, 32'h1234_5678);
    doRead(8'h08, d); check("R4 word at 0B", d, 32'h78EF_7734);
    doWrite(8'h08, 3'd2, 32'hFFFF_0001);
    doRead(8'h08, d); check("R4 half at 08", d, 32'h78EF_0001);
    doWrite(8'h0A, 3'd4, 32'h00AB_00CD);
    doRead(8'h08, d); check("R4 word at 0A", d, 32'h00CD_0001);
  endtask

  task automatic testBadSize();
    logic [31:0] d;
    foreach (expPwr[i]) begin end
    for (int s = 0; s < 8; s++) begin
      if (s == 1 || s == 2 || s == 4) continue;
      doWrite(8'h08, 3'(s), 32'hFFFF_FFFF);
      doWrite(8'h00, 3'(s), 32'h0);
    end
    doRead(8'h08, d); check("R5 pwr unchanged", d, 32'h00CD_0001);
    doRead(8'h00, d); check("R5 ctl unchanged", d, 32'd1);
  endtask

  task automatic testZeroOfs();
    logic [31:0] d;
    logic [7:0] ofs [6] = '{8'h0C, 8'h40, 8'h44, 8'h50, 8'h54, 8'hFC};
    for (int i = 0; i < 6; i++) begin
      doWrite(ofs[i], 3'd4, 32'hFFFF_FFFF);
      doRead(ofs[i], d); check("R6 zero offset", d, 32'd0);
    end
    doRead(8'h08, d); check("R6 pwr untouched", d, expPwr);
    doRead(8'h00, d); check("R6 ctl untouched", d, {31'd0, expCtl});
  endtask

  task automatic testTiming();
    logic [31:0] d;
    doRead(8'h08, d);
    @(negedge clk); regAddr = 8'h00;
    repeat (3) @(negedge clk);
    check("R7 hold while idle", regRdata, expPwr);
    @(negedge clk);
    regAddr = 8'h08; regSize = 3'd4; regWdata = 32'h5555_AAAA; regWrite = 1'b1; regRead = 1'b1;
    @(negedge clk);
    regWrite = 1'b0; regRead = 1'b0;
    check("R7 read sees pre-write", regRdata, expPwr);
    expPwr = 32'h5555_AAAA;
    doRead(8'h08, d); check("R9 next read sees write", d, 32'h5555_AAAA);
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testCtl();
    testCfg();
    testPwr();
    testBadSize();
    testZeroOfs();
    testTiming();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule